// File: doc/BRIEF.md
# Burst-Optimizing Bus Bridge Controller

This controller sits between a FIFO-fed master and an eight-port system bus crossbar. Every transfer request covers two halves of `BEATS_PER_HALF` beats each. A 32-bit control register sets three things: a global enable for read bursts, a global enable for write bursts, and an enable bit for each slave port. The target port comes from the top three address bits. When both the global enable for the direction and the port's own enable bit are set, the block moves each half as one burst transfer on the bus. Otherwise it issues the transfer as individual single-beat accesses.

For a permitted write burst, the block reports an error-free completion for the first half before that half reaches the bus. This lets it pull the second half's data from the FIFO. A sticky bit records the first half's real bus error. A register flag then decides what happens to that error. With the flag clear, the error is dropped. With the flag set, it is folded into the response for the second half. The control fields that matter for a transfer are captured when the transfer is accepted. Register writes made during a transfer therefore apply to the next one.

The sequencer has nine states.
- `ST_IDLE` accepts a request (`req_ready`=1). It goes to `ST_W_ACK1` for a permitted write burst, `ST_R_BUS1` for a permitted read burst, `ST_S_POP` for a single-beat write and `ST_S_BUS` for a single-beat read.
- `ST_W_ACK1` gives the early clean response, pops the first half from the FIFO, and moves to `ST_W_POP2`.
- `ST_W_POP2` pops the second half and moves to `ST_W_BUS1`.
- `ST_W_BUS1` writes the first half. On `bus_done` it latches the sticky error and moves to `ST_W_BUS2`.
- `ST_W_BUS2` writes the second half. On `bus_done` it responds and returns to `ST_IDLE`.
- `ST_R_BUS1` and `ST_R_BUS2` each respond on `bus_done` and then advance. `ST_R_BUS2` returns to `ST_IDLE`.
- `ST_S_POP` pops one beat and moves to `ST_S_BUS`.
- `ST_S_BUS` responds on `bus_done`. After the last beat it returns to `ST_IDLE`. Otherwise it goes to `ST_S_POP` for writes or stays in `ST_S_BUS` for reads.

Top module: `burst_bridge`

## Requirements
- R1: The control register resets to 0 and reads back what was written. Bits use little-endian numbering, where bit 0 is the least significant bit of `cfg_wdata`/`cfg_rdata`. Bit 10 is the accumulate flag, bit 9 the global write-burst enable, bit 8 the global read-burst enable, and bits 7:0 the per-port enables, with bit n belonging to port n.
- R2: Bits 31:11 always read 0 and ignore writes.
- R3: The target port is `req_addr[31:29]`.
- R4: A write is bursted exactly when bit 9 is 1 and port enable bit n is 1. A bursted transfer makes two bus transfers with `bus_burst`=1, at the base address and at base + `BEATS_PER_HALF`*`BEAT_BYTES` (8).
- R5: A read is bursted exactly when bit 8 is 1 and port enable bit n is 1. It uses the same two-transfer bus pattern as R4.
- R6: In a write burst, the first response has `rsp_err`=0 and arrives before any `bus_valid`. Both FIFO pops also happen before the first bus transfer.
- R7: With the accumulate flag at 0, the second write-burst response carries only the second half's bus error.
- R8: With the accumulate flag at 1, the second write-burst response carries the OR of both halves' bus errors.
- R9: A transfer that is not bursted makes 2*`BEATS_PER_HALF` (4) single-beat bus transfers with `bus_burst`=0, at base + 4k. Each beat gives its own response with its own bus error. A write pops the FIFO once per beat.
- R10: In a read burst, each half's response carries that half's own bus error, and the FIFO is never popped.
- R11: The first-half error is cleared when each transfer is accepted, so it never affects a later burst.
- R12: Register writes during a transfer change neither its burst decision nor its accumulate policy.
- R13: `req_ready` is 1 only in idle. After an accept it drops in the next cycle, and it stays low until the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register contents |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Transfer base address |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| fifo_pop | output | 1 | Take one data unit (a half when bursting, a beat when not) from the FIFO |
| rsp_valid | output | 1 | Completion reported to the FIFO side |
| rsp_err | output | 1 | Error flag of that completion |
| bus_valid | output | 1 | Bus transfer active |
| bus_write | output | 1 | Bus transfer direction |
| bus_burst | output | 1 | 1 = half-sized burst, 0 = single beat |
| bus_addr | output | 32 | Bus transfer address |
| bus_done | input | 1 | Bus transfer finished this cycle |
| bus_err | input | 1 | Error status of the finished bus transfer |

## Verification
A wrong sequencer state would show up within a few cycles of an accept, in one of these ways:
- a bus transfer with the wrong burst flag or address;
- a pop count other than 2 or 4;
- a completion arriving after the bus transfer it should precede.

A sticky error that is stale or not latched would show in the very next second-half write response. With the flag at 1, a missing OR would appear in that response. With the flag at 0, an error that leaks through would appear there instead. A snapshot taken at the wrong moment would flip the burst decision of the transfer that was in flight when the register changed.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_ACK1,
        ST_W_POP2,
        ST_W_BUS1,
        ST_W_BUS2,
        ST_R_BUS1,
        ST_R_BUS2,
        ST_S_POP,
        ST_S_BUS
    } seq_state_e;

    localparam int unsigned REG_W = 32;
endpackage

// File: rtl/bbc_ctrl_reg.sv
module bbc_ctrl_reg
    import bbc_pkg::*;
#(
    parameter int unsigned PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic                 acc_en,
    output logic                 wr_glob,
    output logic                 rd_glob,
    output logic [PORTS-1:0]     port_en
);
    localparam int unsigned FIELD_W = PORTS + 3;

    logic [FIELD_W-1:0] field_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (we) begin
            field_q <= wdata[FIELD_W-1:0];
        end
    end

    assign rdata   = {{(REG_W-FIELD_W){1'b0}}, field_q};
    assign port_en = field_q[PORTS-1:0];
    assign rd_glob = field_q[PORTS];
    assign wr_glob = field_q[PORTS+1];
    assign acc_en  = field_q[PORTS+2];

    // R1: a write lands on the next cycle; without a write, contents hold
    p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[FIELD_W-1:0] == $past(wdata[FIELD_W-1:0])));
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));
endmodule

// File: rtl/bbc_permit.sv
module bbc_permit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PORTS  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              wr_glob,
    input  logic              rd_glob,
    input  logic [PORTS-1:0]  port_en,
    output logic              burst_ok
);
    localparam int unsigned IDX_W = (PORTS > 1) ? $clog2(PORTS) : 1;

    logic [IDX_W-1:0] port_idx;
    logic             port_on;

    generate
        if (PORTS > 1) begin : g_multi
            assign port_idx = addr[ADDR_W-1 -: IDX_W];
            assign port_on  = port_en[port_idx];
        end else begin : g_single
            assign port_idx = '0;
            assign port_on  = port_en[0];
        end
    endgenerate

    assign burst_ok = port_on & (write ? wr_glob : rd_glob);
endmodule

// File: rtl/bbc_seq.sv
module bbc_seq
    import bbc_pkg::*;
#(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned BEATS_PER_HALF = 2,
    parameter int unsigned BEAT_BYTES     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              burst_ok,
    input  logic              acc_en,
    output logic              req_ready,
    output logic              fifo_pop,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_done,
    input  logic              bus_err
);
    localparam int unsigned BEATS = 2 * BEATS_PER_HALF;
    localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] HALF_OFS  = ADDR_W'(BEATS_PER_HALF * BEAT_BYTES);
    localparam logic [CNT_W-1:0]  LAST_BEAT = CNT_W'(BEATS - 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic              wr_q, burst_q, acc_q, sticky_q;
    logic [CNT_W-1:0]  beat_q;
    logic              accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (burst_ok) state_d = req_write ? ST_W_ACK1 : ST_R_BUS1;
                    else          state_d = req_write ? ST_S_POP  : ST_S_BUS;
                end
            end
            ST_W_ACK1: state_d = ST_W_POP2;
            ST_W_POP2: state_d = ST_W_BUS1;
            ST_W_BUS1: if (bus_done) state_d = ST_W_BUS2;
            ST_W_BUS2: if (bus_done) state_d = ST_IDLE;
            ST_R_BUS1: if (bus_done) state_d = ST_R_BUS2;
            ST_R_BUS2: if (bus_done) state_d = ST_IDLE;
            ST_S_POP:  state_d = ST_S_BUS;
            ST_S_BUS: begin
                if (bus_done) begin
                    if (beat_q == LAST_BEAT) state_d = ST_IDLE;
                    else                     state_d = wr_q ? ST_S_POP : ST_S_BUS;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and per-transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            base_q   <= '0;
            wr_q     <= 1'b0;
            burst_q  <= 1'b0;
            acc_q    <= 1'b0;
            sticky_q <= 1'b0;
            beat_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_q   <= req_addr;
                wr_q     <= req_write;
                burst_q  <= burst_ok;
                acc_q    <= acc_en;
                sticky_q <= 1'b0;
                beat_q   <= '0;
            end
            if (state_q == ST_W_BUS1 && bus_done) sticky_q <= bus_err;
            if (state_q == ST_S_BUS && bus_done)  beat_q   <= beat_q + 1'b1;
        end
    end

    // outputs per state
    always_comb begin
        req_ready = 1'b0;
        fifo_pop  = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        bus_valid = 1'b0;
        bus_write = wr_q;
        bus_burst = 1'b0;
        bus_addr  = base_q;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_W_ACK1: begin
                rsp_valid = 1'b1;
                fifo_pop  = 1'b1;
            end
            ST_W_POP2: fifo_pop = 1'b1;
            ST_W_BUS1: begin
                bus_valid = 1'b1;
                bus_burst = 1'b1;
            end
            ST_W_BUS2: begin
                bus_valid = 1'b1;
                bus_burst = 1'b1;
                bus_addr  = base_q + HALF_OFS;
                rsp_valid = bus_done;
                rsp_err   = bus_done & (bus_err | (acc_q & sticky_q));
            end
            ST_R_BUS1: begin
                bus_valid = 1'b1;
                bus_burst = 1'b1;
                rsp_valid = bus_done;
                rsp_err   = bus_done & bus_err;
            end
            ST_R_BUS2: begin
                bus_valid = 1'b1;
                bus_burst = 1'b1;
                bus_addr  = base_q + HALF_OFS;
                rsp_valid = bus_done;
                rsp_err   = bus_done & bus_err;
            end
            ST_S_POP:  fifo_pop = 1'b1;
            ST_S_BUS: begin
                bus_valid = 1'b1;
                bus_addr  = base_q + ADDR_W'(beat_q) * STEP;
                rsp_valid = bus_done;
                rsp_err   = bus_done & bus_err;
            end
            default: ;
        endcase
    end

    p_ready_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !fifo_pop && !rsp_valid));
    p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_sticky_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !sticky_q);
    p_early_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && wr_q && burst_q && !bus_valid) |-> (!rsp_err && fifo_pop));
    p_early_pop2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && wr_q && burst_q && !bus_valid) |=> (fifo_pop && !bus_valid));
    p_snapshot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(acc_q) && $stable(burst_q)));
    p_single_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !burst_q) |-> !bus_burst);
    p_accum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done && bus_valid && bus_burst && wr_q && acc_q && sticky_q) |-> rsp_err);
endmodule

// File: rtl/burst_bridge.sv
module burst_bridge
    import bbc_pkg::*;
#(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned PORTS          = 8,
    parameter int unsigned BEATS_PER_HALF = 2,
    parameter int unsigned BEAT_BYTES     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              fifo_pop,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_burst,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_done,
    input  logic              bus_err
);
    logic             acc_en, wr_glob, rd_glob, burst_ok;
    logic [PORTS-1:0] port_en;

    bbc_ctrl_reg #(.PORTS(PORTS)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .acc_en  (acc_en),
        .wr_glob (wr_glob),
        .rd_glob (rd_glob),
        .port_en (port_en)
    );

    bbc_permit #(.ADDR_W(ADDR_W), .PORTS(PORTS)) u_permit (
        .addr     (req_addr),
        .write    (req_write),
        .wr_glob  (wr_glob),
        .rd_glob  (rd_glob),
        .port_en  (port_en),
        .burst_ok (burst_ok)
    );

    bbc_seq #(
        .ADDR_W         (ADDR_W),
        .BEATS_PER_HALF (BEATS_PER_HALF),
        .BEAT_BYTES     (BEAT_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .burst_ok  (burst_ok),
        .acc_en    (acc_en),
        .req_ready (req_ready),
        .fifo_pop  (fifo_pop),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_burst (bus_burst),
        .bus_addr  (bus_addr),
        .bus_done  (bus_done),
        .bus_err   (bus_err)
    );
endmodule

// File: tb/test_burst_bridge.sv
`timescale 1ns/1ps
module test_burst_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, fifo_pop, rsp_valid, rsp_err;
    logic        bus_valid, bus_write, bus_burst;
    logic [31:0] bus_addr;
    logic        bus_done = 1'b0, bus_err = 1'b0;

    always #2 clk = ~clk;

    burst_bridge i_burst_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .fifo_pop(fifo_pop),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_burst(bus_burst), .bus_addr(bus_addr),
        .bus_done(bus_done), .bus_err(bus_err)
    );

    int total = 0, bad = 0;

    // per-transfer log
    int          n_rsp, n_pop, n_bus, pops_pre_bus, first_rsp, first_bus;
    logic        rsp_log [8];
    logic [31:0] addr_log [8];
    logic        burst_log [8];
    logic        wr_log [8];
    logic        ready_after_acc;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_xfer(input logic wr, input logic [31:0] a, input logic [3:0] errs,
                           input bit mid, input logic [31:0] mid_val);
        bit accepted = 0, fin = 0, mid_done = 0, was_acc;
        int wc = 0, cyc = 0;
        n_rsp = 0; n_pop = 0; n_bus = 0; pops_pre_bus = -1;
        first_rsp = -1; first_bus = -1; ready_after_acc = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        while (!fin) begin
            bus_done = 1'b0; bus_err = 1'b0; cfg_we = 1'b0;
            if (bus_valid) begin
                if (first_bus < 0) begin
                    first_bus = cyc; pops_pre_bus = n_pop;
                end
                if (mid && !mid_done) begin
                    cfg_we = 1'b1; cfg_wdata = mid_val; mid_done = 1;
                end
                if (wc == 1) begin
                    bus_done = 1'b1; bus_err = errs[n_bus & 3];
                    addr_log[n_bus] = bus_addr; burst_log[n_bus] = bus_burst;
                    wr_log[n_bus] = bus_write;
                    n_bus++; wc = 0;
                end else wc++;
            end
            #1;
            if (fifo_pop) n_pop++;
            if (rsp_valid) begin
                if (first_rsp < 0) first_rsp = cyc;
                rsp_log[n_rsp & 7] = rsp_err; n_rsp++;
            end
            was_acc = req_valid && req_ready;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (was_acc) begin
                accepted = 1; req_valid = 1'b0;
                ready_after_acc = req_ready;
            end else if (accepted && req_ready) fin = 1;
            if (cyc > 100) begin
                chk(0, "watchdog-xfer", cyc, 100); fin = 1;
            end
        end
        bus_done = 1'b0; bus_err = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic verify(input logic wr, input logic [31:0] a, input logic [3:0] errs,
                          input bit bursted, input bit acc);
        chk(ready_after_acc == 1'b0, "R13 ready low after accept", ready_after_acc, 0);
        if (bursted) begin
            chk(n_bus == 2, wr ? "R3/R4 burst count" : "R3/R5 burst count", n_bus, 2);
            for (int h = 0; h < 2; h++) begin
                chk(burst_log[h] == 1'b1, "R4 burst flag", burst_log[h], 1);
                chk(addr_log[h] == a + 32'(8 * h), "R4 half address", addr_log[h], a + 32'(8 * h));
                chk(wr_log[h] == wr, "R4 bus direction", wr_log[h], wr);
            end
            chk(n_rsp == 2, "R6 response count", n_rsp, 2);
            if (wr) begin
                chk(rsp_log[0] == 1'b0, "R6 early response clean", rsp_log[0], 0);
                chk(first_rsp >= 0 && first_rsp < first_bus, "R6 ack before bus", first_rsp, first_bus);
                chk(pops_pre_bus == 2, "R6 pops before bus", pops_pre_bus, 2);
                if (acc)
                    chk(rsp_log[1] == (errs[0] | errs[1]), "R8 accumulated error", rsp_log[1], errs[0] | errs[1]);
                else
                    chk(rsp_log[1] == errs[1], "R7 discarded error", rsp_log[1], errs[1]);
            end else begin
                chk(rsp_log[0] == errs[0] && rsp_log[1] == errs[1], "R10 read half errors",
                    {rsp_log[0], rsp_log[1]}, {errs[0], errs[1]});
                chk(n_pop == 0, "R10 no pops", n_pop, 0);
            end
        end else begin
            chk(n_bus == 4, "R9 beat count", n_bus, 4);
            chk(n_rsp == 4, "R9 response count", n_rsp, 4);
            for (int k = 0; k < 4; k++) begin
                chk(burst_log[k] == 1'b0, "R9 single flag", burst_log[k], 0);
                chk(addr_log[k] == a + 32'(4 * k), "R9 beat address", addr_log[k], a + 32'(4 * k));
                chk(rsp_log[k] == errs[k], "R9 own beat error", rsp_log[k], errs[k]);
            end
            chk(n_pop == (wr ? 4 : 0), "R9 pops per beat", n_pop, wr ? 4 : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, a;
        logic [7:0]  pen;
        logic [3:0]  e;
        bit          exp_b;
        repeat (3) @(negedge clk);
        // reset state (R1)
        chk(cfg_rdata == 32'h0, "R1 reset value", cfg_rdata, 0);
        chk(req_ready && !bus_valid && !fifo_pop && !rsp_valid, "R13 reset idle",
            {req_ready, bus_valid, fifo_pop, rsp_valid}, 4'b1000);
        rst_n = 1'b1;
        cfg_write(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h0000_07FF, "R2 reserved bits zero", cfg_rdata, 32'h7FF);
        cfg_write(32'h1234_5000 | 32'h0000_0555);
        chk(cfg_rdata == 32'h0000_0555, "R1 readback", cfg_rdata, 32'h555);

        for (int gw = 0; gw < 2; gw++)
        for (int gr = 0; gr < 2; gr++)
        for (int ac = 0; ac < 2; ac++)
        for (int ps = 0; ps < 2; ps++) begin
            pen = ps ? 8'h5A : 8'hA5;
            v = {21'h15A5A5, ac[0], gw[0], gr[0], pen};
            cfg_write(v);
            chk(cfg_rdata == {21'h0, ac[0], gw[0], gr[0], pen}, "R1/R2 field layout",
                cfg_rdata, {21'h0, ac[0], gw[0], gr[0], pen});
            for (int p = 0; p < 8; p++)
            for (int d = 0; d < 2; d++)
            for (int ep = 0; ep < 4; ep++) begin
                a = {p[2:0], 29'h0000_0100};
                e = {ep[1:0], ep[1:0]};
                exp_b = pen[p] & (d ? gw[0] : gr[0]);
                do_xfer(d[0], a, e, 0, 32'h0);
                verify(d[0], a, e, exp_b, ac[0]);
            end
        end

        // R11: sticky first-half error must not reach the next burst
        cfg_write(32'h0000_06FF);
        do_xfer(1'b1, 32'h4000_0200, 4'b0001, 0, 32'h0);
        chk(rsp_log[1] == 1'b1, "R8 first-half error folded", rsp_log[1], 1);
        do_xfer(1'b1, 32'h4000_0200, 4'b0000, 0, 32'h0);
        chk(rsp_log[1] == 1'b0, "R11 no stale error", rsp_log[1], 0);

        // R12: register rewrite during a burst applies afterwards
        do_xfer(1'b1, 32'h2000_0040, 4'b0001, 1, 32'h0000_0000);
        chk(n_bus == 2 && burst_log[0] == 1'b1, "R12 burst decision kept", n_bus, 2);
        chk(rsp_log[1] == 1'b1, "R12 accumulate kept", rsp_log[1], 1);
        chk(cfg_rdata == 32'h0, "R12 new value stored", cfg_rdata, 0);
        do_xfer(1'b1, 32'h2000_0040, 4'b0000, 0, 32'h0);
        chk(n_bus == 4, "R12 next transfer single", n_bus, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule